// File: doc/BRIEF.md
# Load-Driven Interrupt Acknowledge Sequencer

This block lives in a host bridge whose processor has no way to run an interrupt acknowledge bus cycle of its own. The processor reads one reserved address. The block answers that read by running the full two-pulse acknowledge handshake toward an 8259-compatible interrupt controller. It then returns the vector the controller supplied as the read data. Reads to any other address complete at once with zero data.

The controller's interrupt request passes straight through to the processor and is not gated. The width of each acknowledge pulse and the high gap between the two pulses are parameters. The first pulse lets the controller update its in-service state, and the block ignores the data bus during it. The block captures the vector in the last clock cycle of the second pulse.

Top module: `intack_seq`

## Requirements
- R1: `irq_out` equals `irq_in` at all times, with no register in between.
- R2: While reset is asserted and after it is released, `inta_n` is 1, `host_ready` is 0, `host_rdata` is 0x00 and the sequencer is idle.
- R3: A read accepted with `host_addr` not equal to `MAGIC_ADDR` raises `host_ready` in the next cycle with `host_rdata` = 0x00, and `inta_n` stays 1.
- R4: A read accepted with `host_addr` equal to `MAGIC_ADDR` drives exactly two low pulses on `inta_n`, each lasting `PULSE_CYC` cycles (default 4).
- R5: Between the two pulses of one acknowledge, `inta_n` is high for exactly `GAP_CYC` cycles (default 2).
- R6: The returned vector is the value on `vec_in` in the last low cycle of the second pulse. `vec_in` during the first pulse, and earlier in the second pulse, has no effect on the result.
- R7: `host_ready` rises in the cycle in which `inta_n` returns high after the second pulse. It carries the sampled vector on `host_rdata`, so a reserved-address read takes 2*PULSE_CYC+GAP_CYC+1 cycles from acceptance to ready.
- R8: While a sequence runs, `host_ready` stays 0 and a `host_rd` held high starts no second handshake. `host_rdata` is 0x00 whenever `host_ready` is 0.
- R9: `host_ready` is high for exactly one cycle per read. A read is accepted on an edge where `host_rd` is 1 and `host_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Read address from the host |
| host_rd | input | 1 | Read request, held until ready is seen |
| host_ready | output | 1 | One-cycle read completion |
| host_rdata | output | 8 | Read data, valid with host_ready |
| irq_in | input | 1 | Interrupt request from the controller |
| irq_out | output | 1 | Interrupt request to the processor |
| inta_n | output | 1 | Active-low acknowledge pulse to the controller |
| vec_in | input | 8 | Vector bus from the controller |

## Verification
The checker assumes the host keeps `host_rd` and `host_addr` steady from the moment it raises the request until the edge after `host_ready` is seen, and then drops the request for at least one cycle. The bench read task follows that rule exactly. The pulse and gap properties also assume that no other agent drives `inta_n`. The bench's controller stub only reacts to the pulses and never drives the line. The stub puts junk on `vec_in` during the first pulse. It can also change the vector in the last low cycle of the second pulse, which exercises the sampling point without any timing the block does not promise.

// File: rtl/intack_pkg.sv
package intack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK1,
        ST_GAP,
        ST_ACK2,
        ST_DONE
    } seq_state_e;

    localparam int VEC_W = 8;
endpackage

// File: rtl/intack_addr_match.sv
module intack_addr_match #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] MAGIC_ADDR = 16'hFFA0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = (addr == MAGIC_ADDR);
    end
endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
    import intack_pkg::*;
#(
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             hit,
    input  logic [VEC_W-1:0] vec_in,
    output logic             inta_n,
    output logic             ready,
    output logic [VEC_W-1:0] rdata
);
    localparam int MAX_CYC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             inta_n;
        logic             ready;
        logic [VEC_W-1:0] rdata;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state:  ST_IDLE,
        cnt:    '0,
        inta_n: 1'b1,
        ready:  1'b0,
        rdata:  '0
    };

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.ready = 1'b0;
        regs_d.rdata = '0;
        unique case (regs_q.state)
            ST_IDLE: begin
                regs_d.cnt = '0;
                if (rd && !regs_q.ready) begin
                    if (hit) begin
                        regs_d.state  = ST_ACK1;
                        regs_d.inta_n = 1'b0;
                    end else begin
                        regs_d.ready = 1'b1;
                    end
                end
            end
            ST_ACK1: begin
                if (regs_q.cnt == PULSE_LAST) begin
                    regs_d.state  = ST_GAP;
                    regs_d.cnt    = '0;
                    regs_d.inta_n = 1'b1;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (regs_q.cnt == GAP_LAST) begin
                    regs_d.state  = ST_ACK2;
                    regs_d.cnt    = '0;
                    regs_d.inta_n = 1'b0;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_ACK2: begin
                if (regs_q.cnt == PULSE_LAST) begin
                    regs_d.state  = ST_DONE;
                    regs_d.cnt    = '0;
                    regs_d.inta_n = 1'b1;
                    regs_d.ready  = 1'b1;
                    regs_d.rdata  = vec_in;
                end else begin
                    regs_d.cnt = regs_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                regs_d.state = ST_IDLE;
            end
            default: begin
                regs_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RESET_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign inta_n = regs_q.inta_n;
    assign ready  = regs_q.ready;
    assign rdata  = regs_q.rdata;
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] MAGIC_ADDR = 16'hFFA0,
    parameter int              PULSE_CYC  = 4,
    parameter int              GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    output logic              host_ready,
    output logic [7:0]        host_rdata,
    input  logic              irq_in,
    output logic              irq_out,
    output logic              inta_n,
    input  logic [7:0]        vec_in
);
    logic addr_hit;

    assign irq_out = irq_in;

    intack_addr_match #(
        .ADDR_W     (ADDR_W),
        .MAGIC_ADDR (MAGIC_ADDR)
    ) u_match (
        .addr (host_addr),
        .hit  (addr_hit)
    );

    intack_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (host_rd),
        .hit    (addr_hit),
        .vec_in (vec_in),
        .inta_n (inta_n),
        .ready  (host_ready),
        .rdata  (host_rdata)
    );
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd,
    input logic       host_ready,
    input logic [7:0] host_rdata,
    input logic       irq_in,
    input logic       irq_out,
    input logic       inta_n
);
    logic [15:0] low_run_q, high_run_q;
    logic        one_done_q;
    logic        inta_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q   <= '0;
            high_run_q  <= '0;
            one_done_q  <= 1'b0;
            inta_prev_q <= 1'b1;
        end else begin
            inta_prev_q <= inta_n;
            low_run_q   <= inta_n ? 16'd0 : low_run_q + 16'd1;
            high_run_q  <= inta_n ? high_run_q + 16'd1 : 16'd0;
            if (inta_n && !inta_prev_q) begin
                one_done_q <= !one_done_q;
            end
        end
    end

    assert_irq_mirror_R1: assert property (@(posedge clk) irq_out == irq_in);

    assert_reset_state_R2: assert property (@(posedge clk)
        !rst_n |=> (inta_n && !host_ready && host_rdata == 8'h00));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_n && !inta_prev_q) |-> (low_run_q == 16'(PULSE_CYC)));

    assert_gap_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_n && inta_prev_q && one_done_q) |-> (high_run_q == 16'(GAP_CYC)));

    assert_ready_after_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_n && !inta_prev_q && one_done_q) |-> host_ready);

    assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> (host_rdata == 8'h00));

    assert_ready_not_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> inta_n);

    assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_ready_needs_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> host_rd);
endmodule

bind intack_seq intack_seq_chk #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .irq_in     (irq_in),
    .irq_out    (irq_out),
    .inta_n     (inta_n)
);

// File: tb/tb_intack_seq.sv
module tb_intack_seq;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] MAGIC  = 16'hFFA0;
    localparam int          PW     = 4;
    localparam int          GW     = 2;
    localparam int          SEQ_LAT = 2 * PW + GW + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        irq_in = 1'b0;
    logic        irq_out;
    logic        inta_n;
    logic [7:0]  vec_in;

    int n_checks = 0;
    int n_fail   = 0;

    // stub controller state
    logic [7:0] stub_vec  = 8'h00;
    logic       late_mode = 1'b0;
    int         fall_cnt  = 0;
    int         pulse_idx = 0;
    int         cur_low   = 0;
    int         cur_high  = 0;
    int         low_len [2];
    int         gap_len   = 0;
    logic       prev_inta = 1'b1;

    always #10 clk = ~clk;

    intack_seq #(
        .ADDR_W     (ADDR_W),
        .MAGIC_ADDR (MAGIC),
        .PULSE_CYC  (PW),
        .GAP_CYC    (GW)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .irq_in     (irq_in),
        .irq_out    (irq_out),
        .inta_n     (inta_n),
        .vec_in     (vec_in)
    );

    always @(negedge inta_n) begin
        fall_cnt  = fall_cnt + 1;
        pulse_idx = pulse_idx + 1;
    end

    always @(negedge clk) begin
        if (!inta_n) begin
            if (prev_inta && pulse_idx == 2) gap_len = cur_high;
            cur_low  = cur_low + 1;
            cur_high = 0;
        end else begin
            if (!prev_inta && pulse_idx >= 1 && pulse_idx <= 2) low_len[pulse_idx-1] = cur_low;
            cur_high = cur_high + 1;
            cur_low  = 0;
        end
        prev_inta = inta_n;
    end

    always_comb begin
        if (!inta_n && pulse_idx == 2) begin
            if (late_mode && cur_low < PW) vec_in = 8'h11;
            else                           vec_in = stub_vec;
        end else begin
            vec_in = 8'hEE;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] addr, output logic [7:0] data, output int lat);
        pulse_idx = 0;
        low_len[0] = 0;
        low_len[1] = 0;
        gap_len = 0;
        @(negedge clk);
        host_addr = addr;
        host_rd   = 1'b1;
        lat = 0;
        data = 8'h00;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lat++;
            if (host_ready) begin
                data = host_rdata;
                break;
            end
        end
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(inta_n == 1'b1, "R2 inta_n in reset", inta_n, 1);
        check(host_ready == 1'b0, "R2 ready in reset", host_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(inta_n == 1'b1 && host_ready == 1'b0 && host_rdata == 8'h00,
              "R2 idle after reset", {inta_n, host_ready, host_rdata}, 10'h200);
    endtask

    task automatic t_irq;
        irq_in = 1'b1;
        #1;
        check(irq_out == 1'b1, "R1 irq high", irq_out, 1);
        irq_in = 1'b0;
        #1;
        check(irq_out == 1'b0, "R1 irq low", irq_out, 0);
    endtask

    task automatic t_plain_read(input logic [15:0] addr);
        logic [7:0] d;
        int lat;
        int f0;
        f0 = fall_cnt;
        do_read(addr, d, lat);
        check(d == 8'h00, "R3 plain read data", d, 0);
        check(lat == 1, "R3 plain read latency", lat, 1);
        check(fall_cnt == f0, "R3 no inta on plain read", fall_cnt - f0, 0);
    endtask

    task automatic t_magic_read(input logic [7:0] vec, input logic late);
        logic [7:0] d;
        int lat;
        int f0;
        stub_vec  = vec;
        late_mode = late;
        f0 = fall_cnt;
        do_read(MAGIC, d, lat);
        repeat (3) @(negedge clk);
        check(fall_cnt - f0 == 2, "R4 two pulses", fall_cnt - f0, 2);
        check(low_len[0] == PW, "R4 first pulse width", low_len[0], PW);
        check(low_len[1] == PW, "R4 second pulse width", low_len[1], PW);
        check(gap_len == GW, "R5 gap width", gap_len, GW);
        check(d == vec, late ? "R6 late vector sampling" : "R6 vector value", d, vec);
        check(lat == SEQ_LAT, "R7 ready latency", lat, SEQ_LAT);
        check(host_ready == 1'b0 && host_rdata == 8'h00, "R8 idle data zero",
              host_rdata, 0);
        late_mode = 1'b0;
    endtask

    task automatic t_held_rd;
        int f0;
        int ready_seen;
        f0 = fall_cnt;
        ready_seen = 0;
        stub_vec = 8'h3C;
        pulse_idx = 0;
        @(negedge clk);
        host_addr = MAGIC;
        host_rd   = 1'b1;
        for (int i = 0; i < SEQ_LAT - 1; i++) begin
            @(negedge clk);
            if (host_ready) ready_seen++;
        end
        check(ready_seen == 0, "R8 ready low during sequence", ready_seen, 0);
        @(negedge clk);
        check(host_ready == 1'b1 && host_rdata == 8'h3C, "R7 ready with vector",
              host_rdata, 8'h3C);
        @(negedge clk);
        check(host_ready == 1'b0, "R9 ready single cycle", host_ready, 0);
        host_rd = 1'b0;
        check(fall_cnt - f0 == 2, "R8 no overlapping handshake", fall_cnt - f0, 2);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        low_len[0] = 0;
        low_len[1] = 0;
        t_reset();
        t_irq();
        t_plain_read(16'h0020);
        t_plain_read(16'hFFA1);
        t_magic_read(8'h5A, 1'b0);
        t_magic_read(8'hC3, 1'b0);
        t_magic_read(8'h99, 1'b1);
        t_held_rd();
        t_plain_read(16'h0000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule